// File: doc/BRIEF.md
# ADC Conversion Phase Timer

This block produces the timing of a single conversion of a successive-approximation converter. All timing is counted in converter clock cycles. A 3-bit code selects the sampling time and a 2-bit code selects the result resolution. One pulse on the start input starts one conversion. The block then opens a sampling window, followed by a processing window. It raises an end-of-sampling pulse as sampling finishes, and a done pulse as processing finishes. A busy output covers the whole conversion.

Both phase lengths are specified as a whole number of cycles plus one half cycle. The two halves always add up to one full cycle. The block therefore stretches the sampling window by half a cycle up to a whole cycle, and trims the processing window by half a cycle down to a whole cycle. The total stays exact. Both codes are captured when a start is accepted, so the core's controller can change them freely while a conversion is under way.

Top module: `adc_conv_timer`

## Requirements
- R1: While reset is asserted and right after it, busy, both windows, the end-of-sampling pulse and the done pulse are all low.
- R2: The sampling window lasts 2, 8, 14, 29, 42, 56, 72 or 240 cycles for sampling codes 0 to 7. These are 1.5, 7.5, 13.5, 28.5, 41.5, 55.5, 71.5 and 239.5 cycles, each rounded up.
- R3: The processing window lasts 12, 10, 8 or 6 cycles for resolution codes 0 (12-bit), 1 (10-bit), 2 (8-bit) and 3 (6-bit). These are 12.5, 10.5, 8.5 and 6.5 cycles, each rounded down.
- R4: A start sampled high at a clock edge while busy is low makes busy and the sampling window high from that edge on.
- R5: The total number of busy cycles equals the sampling time plus the processing time. For example, code 0 at 12-bit gives 14 cycles.
- R6: The end-of-sampling pulse is high for exactly one cycle, in the last cycle of the sampling window. The processing window starts in the next cycle.
- R7: The done pulse is high for exactly one cycle, in the last cycle of the processing window. Busy and the processing window fall at the following edge.
- R8: A start sampled while busy is high, including the done cycle, is ignored. It neither shortens nor restarts the conversion, and busy is low after done.
- R9: Both codes are captured at the accepted start. Changing them during a conversion does not alter its phase lengths.
- R10: The sampling and processing windows are never high together, and busy is high exactly when one of them is high.
- R11: A start in the first idle cycle after done is accepted with no gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Converter clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request one conversion; honoured only when idle |
| smp_code_i | input | 3 | Sampling-time code, captured at accepted start |
| res_code_i | input | 2 | Resolution code, captured at accepted start |
| busy_o | output | 1 | High through the whole conversion |
| smp_win_o | output | 1 | Sampling phase window |
| proc_win_o | output | 1 | Processing phase window |
| eosmp_o | output | 1 | One-cycle pulse on the last sampling cycle |
| done_o | output | 1 | One-cycle pulse on the last processing cycle |

## Verification
The assertions assume that reset is asserted before the first edge. They also assume that start and both codes are free of X and change only away from the rising edge. Every value of the two codes is legal, so none of the properties needs to filter the codes. The bench changes all inputs on the falling edge and holds reset for several cycles. It drives start both while idle and while busy, so the properties on ignored starts and phase hand-over are exercised from both sides.

// File: rtl/adc_tmr_pkg.sv
package adc_tmr_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_SAMP = 2'd1,
      PH_PROC = 2'd2
   } phase_e;

   localparam int SMP_CODE_W  = 3;
   localparam int RES_CODE_W  = 2;
   localparam int SMP_MAX_CYC = 240;

   // Sampling time N.5 cycles, rounded up to N+1 whole cycles.
   function automatic int smp_whole_cycles(input logic [SMP_CODE_W-1:0] code);
      int r;
      case (code)
         3'd0: r = 2;
         3'd1: r = 8;
         3'd2: r = 14;
         3'd3: r = 29;
         3'd4: r = 42;
         3'd5: r = 56;
         3'd6: r = 72;
         default: r = 240;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/adc_tmr_smp_lut.sv
module adc_tmr_smp_lut
   import adc_tmr_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic [SMP_CODE_W-1:0] code_i,
   output logic [CNT_W-1:0]      cyc_o
);

   always_comb begin
      cyc_o = CNT_W'(smp_whole_cycles(code_i));
   end

endmodule

// File: rtl/adc_tmr_proc_lut.sv
module adc_tmr_proc_lut
   import adc_tmr_pkg::*;
#(
   parameter int CNT_W     = 8,
   parameter int PROC_BASE = 12,
   parameter int PROC_STEP = 2
) (
   input  logic [RES_CODE_W-1:0] res_i,
   output logic [CNT_W-1:0]      cyc_o
);

   localparam int N_RES = 1 << RES_CODE_W;
   localparam int PROC_MIN = PROC_BASE - PROC_STEP * (N_RES - 1);

   if (PROC_MIN < 1) begin : g_bad_min
      $error("processing length must stay at least one cycle");
   end
   if (PROC_BASE >= (1 << CNT_W)) begin : g_bad_w
      $error("CNT_W too narrow for processing length");
   end

   logic [CNT_W-1:0] tbl [N_RES];

   for (genvar g = 0; g < N_RES; g++) begin : g_tbl
      // N.5 processing cycles trimmed to N whole cycles
      assign tbl[g] = CNT_W'(PROC_BASE - PROC_STEP * g);
   end

   assign cyc_o = tbl[res_i];

endmodule

// File: rtl/adc_tmr_seq.sv
module adc_tmr_seq
   import adc_tmr_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic [CNT_W-1:0] smp_cyc_i,
   input  logic [CNT_W-1:0] proc_cyc_i,
   output logic             busy_o,
   output logic             smp_o,
   output logic             proc_o,
   output logic             eos_o,
   output logic             done_o
);

   phase_e           ph_q;
   logic [CNT_W-1:0] cnt_q;
   logic             last_w;

   assign last_w = (cnt_q == '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ph_q  <= PH_IDLE;
         cnt_q <= '0;
      end else begin
         case (ph_q)
            PH_IDLE: begin
               if (start_i) begin
                  ph_q  <= PH_SAMP;
                  cnt_q <= smp_cyc_i - CNT_W'(1);
               end
            end
            PH_SAMP: begin
               if (last_w) begin
                  ph_q  <= PH_PROC;
                  cnt_q <= proc_cyc_i - CNT_W'(1);
               end else begin
                  cnt_q <= cnt_q - CNT_W'(1);
               end
            end
            PH_PROC: begin
               if (last_w) ph_q <= PH_IDLE;
               else        cnt_q <= cnt_q - CNT_W'(1);
            end
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   assign smp_o  = (ph_q == PH_SAMP);
   assign proc_o = (ph_q == PH_PROC);
   assign busy_o = (ph_q != PH_IDLE);
   assign eos_o  = smp_o && last_w;
   assign done_o = proc_o && last_w;

   a_r4_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i && !busy_o |=> smp_o);
   a_r6_smp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      smp_o && !eos_o |=> smp_o);
   a_r6_eos_to_proc: assert property (@(posedge clk_i) disable iff (!rst_ni)
      eos_o |=> proc_o);
   a_r7_proc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      proc_o && !done_o |=> proc_o);
   a_r7_done_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !busy_o);
   a_r8_stay_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o && !done_o |=> busy_o);
   a_r10_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({smp_o, proc_o}));

endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer
   import adc_tmr_pkg::*;
#(
   parameter int CNT_W     = 8,
   parameter int PROC_BASE = 12,
   parameter int PROC_STEP = 2
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  start_i,
   input  logic [SMP_CODE_W-1:0] smp_code_i,
   input  logic [RES_CODE_W-1:0] res_code_i,
   output logic                  busy_o,
   output logic                  smp_win_o,
   output logic                  proc_win_o,
   output logic                  eosmp_o,
   output logic                  done_o
);

   if ((1 << CNT_W) <= SMP_MAX_CYC) begin : g_bad_cnt
      $error("CNT_W too narrow for longest sampling window");
   end

   logic [RES_CODE_W-1:0] res_q;
   logic [CNT_W-1:0]      smp_cyc;
   logic [CNT_W-1:0]      proc_cyc;
   logic                  accept;

   assign accept = start_i && !busy_o;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     res_q <= '0;
      else if (accept) res_q <= res_code_i;
   end

   adc_tmr_smp_lut #(.CNT_W(CNT_W)) u_smp (
      .code_i (smp_code_i),
      .cyc_o  (smp_cyc)
   );

   adc_tmr_proc_lut #(
      .CNT_W     (CNT_W),
      .PROC_BASE (PROC_BASE),
      .PROC_STEP (PROC_STEP)
   ) u_proc (
      .res_i (res_q),
      .cyc_o (proc_cyc)
   );

   adc_tmr_seq #(.CNT_W(CNT_W)) u_seq (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .start_i    (start_i),
      .smp_cyc_i  (smp_cyc),
      .proc_cyc_i (proc_cyc),
      .busy_o     (busy_o),
      .smp_o      (smp_win_o),
      .proc_o     (proc_win_o),
      .eos_o      (eosmp_o),
      .done_o     (done_o)
   );

   a_r9_res_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |=> $stable(res_q));
   a_r10_busy_cover: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |-> (smp_win_o || proc_win_o));

endmodule

// File: tb/adc_conv_timer_test.sv
module adc_conv_timer_test;

   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [2:0] smp = '0;
   logic [1:0] res = '0;
   logic       busy, smp_win, proc_win, eosmp, done;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   adc_conv_timer uut (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .start_i    (start),
      .smp_code_i (smp),
      .res_code_i (res),
      .busy_o     (busy),
      .smp_win_o  (smp_win),
      .proc_win_o (proc_win),
      .eosmp_o    (eosmp),
      .done_o     (done)
   );

   localparam int V_SMP [8] = '{0, 1, 2, 3, 4, 5, 6, 7};
   localparam int V_RES [8] = '{0, 1, 2, 3, 0, 1, 2, 3};
   localparam int V_ES  [8] = '{2, 8, 14, 29, 42, 56, 72, 240};
   localparam int V_EP  [8] = '{12, 10, 8, 6, 12, 10, 8, 6};

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // mode 0: plain, 1: codes changed + start pokes mid-run, 2: start poked in done cycle
   task automatic run_conv(input int sc, input int rc, input int es, input int ep, input int mode);
      int s_n = 0, p_n = 0, tot = 0, e_n = 0, d_n = 0, e_at = 0, d_at = 0;
      bit excl_bad = 0, cover_bad = 0;
      @(negedge clk);
      start = 1'b1;
      smp = 3'(sc);
      res = 2'(rc);
      @(negedge clk);
      start = 1'b0;
      chk(busy && smp_win, "R4 start accepted", int'({busy, smp_win}), 3);
      if (mode == 1) begin
         smp = ~3'(sc);
         res = ~2'(rc);
      end
      while (busy && tot < 400) begin
         if (smp_win) s_n++;
         if (proc_win) p_n++;
         if (smp_win && proc_win) excl_bad = 1;
         if (!(smp_win || proc_win)) cover_bad = 1;
         if (eosmp) begin e_n++; e_at = s_n; end
         if (done) begin d_n++; d_at = p_n; end
         tot++;
         start = (mode == 1 && (tot == 3 || tot == es + 1)) ||
                 (mode == 2 && done);
         @(negedge clk);
      end
      start = 1'b0;
      chk(s_n == es, "R2 sampling window", s_n, es);
      chk(p_n == ep, "R3 processing window", p_n, ep);
      chk(tot == es + ep, "R5 total busy", tot, es + ep);
      chk(e_n == 1 && e_at == es, "R6 eosmp last sampling cycle", e_at, es);
      chk(d_n == 1 && d_at == ep, "R7 done last processing cycle", d_at, ep);
      chk(!excl_bad && !cover_bad, "R10 windows exclusive", int'({excl_bad, cover_bad}), 0);
      chk(!smp_win && !proc_win, "R7 windows fall with busy", int'({smp_win, proc_win}), 0);
      if (mode == 1) chk(tot == es + ep, "R9 codes held and R8 mid starts ignored", tot, es + ep);
      @(negedge clk);
      chk(!busy, "R8 idle after done", int'(busy), 0);
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!busy && !smp_win && !proc_win && !eosmp && !done, "R1 reset outputs",
          int'({busy, smp_win, proc_win, eosmp, done}), 0);
      start = 1'b1;
      @(negedge clk);
      chk(!busy, "R1 start ignored in reset", int'(busy), 0);
      start = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done, "R1 idle after reset", int'({busy, done}), 0);

      for (int i = 0; i < 8; i++) run_conv(V_SMP[i], V_RES[i], V_ES[i], V_EP[i], 0);

      // R9 and R8: codes changed and starts poked mid-conversion
      run_conv(0, 0, 2, 12, 1);
      run_conv(3, 2, 29, 8, 1);
      // R8: start in the done cycle is ignored
      run_conv(1, 3, 8, 6, 2);

      // R11: back-to-back start right after done
      begin
         int tot = 0;
         @(negedge clk);
         start = 1'b1; smp = 3'd0; res = 2'd3;
         @(negedge clk);
         start = 1'b0;
         while (busy && !done && tot < 400) begin tot++; @(negedge clk); end
         @(negedge clk);
         chk(!busy, "R11 first conversion ended", int'(busy), 0);
         start = 1'b1; smp = 3'd2; res = 2'd1;
         @(negedge clk);
         start = 1'b0;
         chk(busy && smp_win, "R11 immediate restart", int'({busy, smp_win}), 3);
         tot = 0;
         while (busy && tot < 400) begin tot++; @(negedge clk); end
         chk(tot == 24, "R11 R5 restart length", tot, 24);
      end

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule